// File: doc/BRIEF.md
# Scanline Serial-Flash Fetch and Display Engine

This block pulls a fixed run of bits out of an external serial flash on every visible video line and paints them as monochrome pixels. A separate timing generator supplies the horizontal and vertical beam counters and the sync pulses. The engine opens one read transaction per active line, framed only by chip select, while the serial clock is simply the inverted system clock and never stops.

Active lines form groups of four, and the groups alternate between two treatments. In a buffered group the bits fetched on one line are shifted into a capture register, copied to a display register at the end of the fetch, and shown on the following line. The first line of a buffered group therefore has nothing to show and is forced dark. In a direct group the live serial data input drives the colour outputs with no register in between. Both treatments place data bit j at the same beam column, so the two kinds of lines can be compared on screen. A select input chooses whether the colour and sync outputs leave through flip-flops or straight from the logic.

Top module: `scanline_flash_fetch`

## Requirements
- R1: `spi_cs_n` is low exactly while `rst_n` is high, `vpos < V_ACTIVE` and `DATA_X-32 <= hpos < DATA_X+NBITS`; it is high at all other times, reset included.
- R2: Counting cycles of an open transaction from 0, cycles 0..31 put out on `spi_mosi`, MSB first, the 32-bit header made of the read command 0x03 followed by the 24-bit byte address. `spi_mosi` is low in every other cycle.
- R3: The byte address equals 17 times (`vpos` / 8), so it advances by 17 bytes per pair of groups and is 0 again at the top of every frame.
- R4: `spi_sclk` is the inverse of `clk`. `spi_miso` is sampled on the rising edge of `clk`, and data bit j (MSB of the first byte is bit 0) is expected on it during cycle 32+j of the transaction.
- R5: On a buffered line (`vpos[2]` = 0, `vpos[1:0]` != 0), in the cycle where `hpos` = DATA_X+j, 0 <= j < NBITS, every colour bit shows data bit j captured on the previous line.
- R6: The first line of each buffered group (`vpos[2:0]` = 0) is dark over the whole line.
- R7: On a direct line (`vpos[2]` = 1), in the cycle where `hpos` = DATA_X+j, every colour bit equals the live `spi_miso` level with no register in between.
- R8: The colour outputs are 0 outside `DATA_X <= hpos < DATA_X+NBITS`, on lines with `vpos >= V_ACTIVE`, and while the chip select is high.
- R9: With `out_reg_en` high, `rgb`, `hsync` and `vsync` carry the values of the previous cycle's combinational colour, `hs_in` and `vs_in`. These registers are 0 in the first cycle after reset. With `out_reg_en` low they carry the values of the same cycle.
- R10: `spi_rst_n`, `spi_wp_n` and `spi_hold_n` are high whenever `rst_n` is high and low while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hpos | input | H_W | Horizontal beam counter from the timing block |
| vpos | input | V_W | Vertical beam counter from the timing block |
| hs_in | input | 1 | Horizontal sync from the timing block |
| vs_in | input | 1 | Vertical sync from the timing block |
| out_reg_en | input | 1 | 1 sends colour and sync through flip-flops |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, inverted system clock |
| spi_mosi | output | 1 | Serial command and address to the flash |
| spi_rst_n | output | 1 | Flash reset pin, held inactive |
| spi_wp_n | output | 1 | Flash write-protect pin, held inactive |
| spi_hold_n | output | 1 | Flash hold pin, held inactive |
| rgb | output | 3 | Colour outputs, all three bits carry the pixel |
| hsync | output | 1 | Horizontal sync out |
| vsync | output | 1 | Vertical sync out |

## Verification
The capture of the current line's bits and the display of the previous line's bits fall in the same cycles: both registers shift across the whole data window, and the display register is reloaded one cycle after the last capture. A mistake here would show stale or half-shifted bits in the buffered lines. The bench drives a flash model whose bytes follow an address-dependent pattern with no short period. For every cycle it predicts each pixel from the requirements as the flash bit at that column, so a bit shown one column early or late, or taken from the wrong line, is a mismatch. The output-register select is also switched mid-line in one frame, so that the combinational and registered paths are compared in the same cycle in which a new bit reaches the colour outputs.

// File: rtl/scanline_flash_fetch.sv
module scanline_flash_fetch #(
  parameter int H_W      = 11,
  parameter int V_W      = 10,
  parameter int DATA_X   = 200,
  parameter int NBITS    = 136,
  parameter int V_ACTIVE = 480
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [H_W-1:0] hpos,
  input  logic [V_W-1:0] vpos,
  input  logic           hs_in,
  input  logic           vs_in,
  input  logic           out_reg_en,
  input  logic           spi_miso,
  output logic           spi_cs_n,
  output logic           spi_sclk,
  output logic           spi_mosi,
  output logic           spi_rst_n,
  output logic           spi_wp_n,
  output logic           spi_hold_n,
  output logic [2:0]     rgb,
  output logic           hsync,
  output logic           vsync
);
  localparam int HDR_BITS = 32;
  localparam logic [H_W-1:0] WIN_LO  = H_W'(DATA_X - HDR_BITS);
  localparam logic [H_W-1:0] DISP_LO = H_W'(DATA_X);
  localparam logic [H_W-1:0] WIN_HI  = H_W'(DATA_X + NBITS);
  localparam logic [V_W-1:0] V_END   = V_W'(V_ACTIVE);
  localparam logic [7:0]     READ_OP = 8'h03;

  logic             active_line, in_win, fetch, data_phase;
  logic             buffered, blank_line, pix;
  logic [H_W-1:0]   idx;
  logic [V_W-4:0]   pair;
  logic [23:0]      flash_addr;
  logic [31:0]      hdr;
  logic [NBITS-1:0] cap, disp;
  logic [2:0]       rgb_raw, rgb_q;
  logic             hs_q, vs_q;

  assign spi_sclk   = ~clk;
  assign spi_rst_n  = rst_n;
  assign spi_wp_n   = rst_n;
  assign spi_hold_n = rst_n;

  assign active_line = vpos < V_END;
  assign in_win      = (hpos >= WIN_LO) && (hpos < WIN_HI);
  assign fetch       = rst_n && active_line && in_win;
  assign data_phase  = fetch && (hpos >= DISP_LO);
  assign idx         = hpos - WIN_LO;

  assign pair       = vpos[V_W-1:3];
  assign flash_addr = 24'({pair, 4'b0000}) + 24'(pair);
  assign hdr        = {READ_OP, flash_addr};

  assign spi_cs_n = !fetch;
  assign spi_mosi = fetch && !data_phase && hdr[5'd31 - idx[4:0]];

  assign buffered   = !vpos[2];
  assign blank_line = buffered && (vpos[1:0] == 2'b00);
  assign pix        = data_phase && !blank_line && (buffered ? disp[NBITS-1] : spi_miso);
  assign rgb_raw    = {3{pix}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap   <= '0;
      disp  <= '0;
      rgb_q <= '0;
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      if (data_phase) begin
        cap  <= {cap[NBITS-2:0], spi_miso};
        disp <= {disp[NBITS-2:0], 1'b0};
      end else if (hpos == WIN_HI) begin
        disp <= cap;
      end
      rgb_q <= rgb_raw;
      hs_q  <= hs_in;
      vs_q  <= vs_in;
    end
  end

  assign rgb   = out_reg_en ? rgb_q : rgb_raw;
  assign hsync = out_reg_en ? hs_q  : hs_in;
  assign vsync = out_reg_en ? vs_q  : vs_in;

  p_cs_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(spi_cs_n) |-> hpos == WIN_LO);

  p_cs_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(spi_cs_n) |-> $past(hpos) == WIN_HI - H_W'(1));

  p_cmd_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(spi_cs_n) |-> !spi_mosi);

  p_blank_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blank_line |-> rgb_raw == 3'b000);

  p_dark_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> rgb_raw == 3'b000);

  p_reg_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_reg_en && $past(rst_n) |-> rgb == $past(rgb_raw) && hsync == $past(hs_in) && vsync == $past(vs_in));
endmodule

// File: tb/test_scanline_flash_fetch.sv
`timescale 1ns/1ps
module test_scanline_flash_fetch;
  localparam int H_W = 11, V_W = 10, DATA_X = 200, NBITS = 136, V_ACT = 16;
  localparam int H_TOT = 400, V_TOT = 20, FRAMES = 4;
  localparam int WLO = DATA_X - 32, WHI = DATA_X + NBITS;

  logic clk, rst_n, hs_in, vs_in, out_reg_en, spi_miso;
  logic [H_W-1:0] hpos;
  logic [V_W-1:0] vpos;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_rst_n, spi_wp_n, spi_hold_n, hsync, vsync;
  logic [2:0] rgb;
  int compared = 0, mismatched = 0;
  bit done = 0;

  scanline_flash_fetch #(.H_W(H_W), .V_W(V_W), .DATA_X(DATA_X), .NBITS(NBITS), .V_ACTIVE(V_ACT))
    i_scanline_flash_fetch (.clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .hs_in(hs_in),
      .vs_in(vs_in), .out_reg_en(out_reg_en), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_rst_n(spi_rst_n), .spi_wp_n(spi_wp_n),
      .spi_hold_n(spi_hold_n), .rgb(rgb), .hsync(hsync), .vsync(vsync));

  initial begin clk = 0; forever #4 clk = ~clk; end

  function automatic logic fbit(input int a, input int j);
    int b, v;
    b = a + j / 8;
    v = ((b * 37 + 11) ^ (b >> 3)) & 255;
    return v[7 - (j % 8)];
  endfunction

  // flash model: shifts MOSI on rising SCLK, drives MISO on falling SCLK
  int fcnt = 0;
  logic [31:0] fsh = '0;
  initial forever begin
    @(negedge clk);
    if (spi_cs_n) fcnt = 0;
    else begin
      if (fcnt < 32) fsh = {fsh[30:0], spi_mosi};
      fcnt++;
    end
  end
  initial begin
    spi_miso = 0;
    forever begin
      @(posedge clk);
      if (!spi_cs_n && fcnt >= 32 && fsh[31:24] == 8'h03) spi_miso <= fbit(int'(fsh[23:0]), fcnt - 32);
      else spi_miso <= 1'b0;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at t=%0t h=%0d v=%0d actual=%0d expected=%0d", tag, $time, hpos, vpos, act, exp);
    end
  endtask

  // reference model, compared every cycle
  initial begin
    int last_raw = 0, prev_rst = 0;
    @(posedge clk);
    while (!done) begin
      int h, v, idx, addr, pix, raw, oexp;
      bit act;
      string ptag;
      @(posedge clk); #2;
      h = int'(hpos); v = int'(vpos);
      act = rst_n && v < V_ACT && h >= WLO && h < WHI;
      idx = h - WLO;
      addr = (v / 8) * 17;
      cmp("R1 chip select", spi_cs_n, !act);
      cmp("R2 R3 header bit", spi_mosi, (act && idx < 32) ? ((32'h0300_0000 | addr) >> (31 - idx)) & 1 : 0);
      cmp("R4 sclk", spi_sclk, 0);
      cmp("R10 flash pins", {spi_rst_n, spi_wp_n, spi_hold_n}, rst_n ? 7 : 0);
      pix = (act && idx >= 32 && (v % 8) != 0) ? fbit(addr, idx - 32) : 0;
      if (!act || idx < 32) ptag = "R8 dark";
      else if ((v % 8) == 0) ptag = "R6 blank";
      else if (v % 8 >= 4) ptag = "R7 direct R4";
      else ptag = "R5 buffered R4";
      raw = (hs_in << 4) | (vs_in << 3) | (pix ? 7 : 0);
      oexp = out_reg_en ? (prev_rst ? last_raw : 0) : raw;
      if (out_reg_en) cmp("R9 registered outputs", {hsync, vsync, rgb}, oexp);
      else cmp(ptag, {hsync, vsync, rgb}, oexp);
      last_raw = raw;
      prev_rst = rst_n;
    end
  end

  initial begin
    rst_n = 0; hpos = '0; vpos = '0; hs_in = 1; vs_in = 1; out_reg_en = 0;
    repeat (5) @(posedge clk);
    rst_n <= 1;
    for (int f = 0; f < FRAMES; f++)
      for (int v = 0; v < V_TOT; v++)
        for (int h = 0; h < H_TOT; h++) begin
          @(posedge clk);
          hpos <= H_W'(h);
          vpos <= V_W'(v);
          hs_in <= !(h >= 380 && h < 390);
          vs_in <= !(v == 18);
          case (f)
            1: out_reg_en <= 1;
            3: out_reg_en <= ((h + v * 7) % 5) < 2;
            default: out_reg_en <= 0;
          endcase
        end
    repeat (3) @(posedge clk);
    done = 1;
    @(posedge clk); #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule